// File: doc/BRIEF.md
# PCI Configuration Header Responder

This block answers configuration-space accesses for a small serial controller that exposes one or two I/O BARs. It keeps a 256-byte type-0 header image. Most of the image is constant. A few fields are writable: each active BAR and the interrupt line byte. An access arrives on a simple synchronous bus as a one-cycle request with a byte address, four byte enables and a 32-bit write word. The block acknowledges each access with a one-cycle `ack`, and for reads it returns the addressed dword on its natural byte lanes.

Writes follow a fixed rule for each offset. An active BAR answers the usual sizing probe: a write of all ones reads back the 8-byte I/O window mask. Any other full write stores a new base address. In both cases the two low bits of the BAR stay as they were. BAR1 exists only when the `NUM_PORTS` parameter is 2; otherwise it is hardwired to zero. The interrupt pin is read-only. Writes to every other offset leave the image unchanged.

A three-state controller sequences each access. `ST_IDLE` goes to `ST_EXEC` when a request is accepted. `ST_EXEC` always goes to `ST_DONE`, and on that edge the write is applied or the read word is registered. `ST_DONE` raises `ack`. From there it returns to `ST_IDLE`, or, if a new request is present in that cycle, it goes straight back to `ST_EXEC`.

Top module: `pci_cfg_responder`

## Requirements
- R1: After reset the image reads: dword 0x04 = 0x02000001, dword 0x08 = 0x07000210, BAR0 (0x10) = 0x00000001, dword 0x34 = 0, dword 0x3C = 0x00000100 (interrupt pin 0x01 in byte 1, interrupt line 0 in byte 0). With two ports, BAR1 (0x14) also reads 0x00000001.
- R2: A request is accepted only in `ST_IDLE` or `ST_DONE`. A request raised in `ST_EXEC` is dropped. `ack` is high for exactly the second cycle after the accepting edge and is low in the cycle between. `rdata` is valid while `ack` is high and is zero for writes.
- R3: Byte lane k of `rdata` (bits 8k+7:8k) carries header byte 4*dword+k when `be[k]` is 1 and is zero otherwise. `addr[1:0]` does not affect reads.
- R4: Reads at addresses of 0x100 and above return zero. Writes at those addresses change nothing, and in particular they do not alias onto the low 256 bytes.
- R5: A full write of 0xFFFFFFFF to an active BAR makes it read 0xFFFFFFF9: the sizing mask is the two's complement of the 8-byte I/O window, and the low two bits are kept.
- R6: Any other full write to an active BAR stores bits 31:2 of the written word and keeps bits 1:0 (the I/O flag 01). For example, writing 0x0000C0F2 reads back 0x0000C0F1.
- R7: With `NUM_PORTS`=2, BAR1 behaves like BAR0 (R5, R6). With `NUM_PORTS`=1, BAR1 reads zero after reset and after any write.
- R8: BAR2, BAR3 and BAR4 (0x18, 0x1C, 0x20) read zero after any write.
- R9: Writes to command/status (0x04), the class dword (0x08), the capability pointer and every other non-writable offset leave the readback unchanged.
- R10: A write to dword 0x3C with `be[0]`=1 stores `wdata[7:0]` as the interrupt line. The interrupt pin byte stays 0x01 whatever the byte enables are.
- R11: BAR write rules apply only to full writes (`be`=4'hF with `addr[1:0]`=0). Partial or misaligned writes to a BAR are ignored.
- R12: A read accepted in the `ack` cycle of a write returns the value that write produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| be | input | 4 | Byte enables, one per lane |
| wdata | input | 32 | Write word |
| ack | output | 1 | Access complete, one cycle |
| rdata | output | 32 | Read word, valid with ack |

## Verification
Two things can happen in the same cycle: a write completing and the next request being accepted. When `req` is present in `ST_DONE`, the write's `ack` and the capture of the following read share one clock edge. The bench provokes this by raising a read of BAR0 during the `ack` cycle of a BAR0 address write. It then checks that the read is acknowledged two cycles later with the newly written base and the preserved I/O flag. The opposite overlap, a request raised during `ST_EXEC`, is judged by reading back the interrupt line and finding it unchanged.

// File: rtl/cfg_resp_pkg.sv
package cfg_resp_pkg;

    // header geometry
    localparam int HDR_BYTES = 256;
    localparam int HDR_DW_W  = $clog2(HDR_BYTES / 4);
    localparam int MAX_BARS  = 2;

    // dword indices whose behaviour the block depends on
    localparam logic [HDR_DW_W-1:0] DW_CMD   = 6'h01;
    localparam logic [HDR_DW_W-1:0] DW_CLASS = 6'h02;
    localparam logic [HDR_DW_W-1:0] DW_BAR0  = 6'h04;
    localparam logic [HDR_DW_W-1:0] DW_INTR  = 6'h0F;

    // constant image contents
    localparam logic [31:0] CMD_STAT_VAL = 32'h0200_0001;
    localparam logic [31:0] CLASS_VAL    = 32'h0700_0210;
    localparam logic [31:0] BAR_IO_RST   = 32'h0000_0001;
    localparam logic [7:0]  INT_PIN_VAL  = 8'h01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_t;

    typedef struct packed {
        logic                we;
        logic [3:0]          be;
        logic [HDR_DW_W-1:0] dw;
        logic                in_hdr;
        logic                aligned;
        logic [31:0]         wdata;
    } cfg_req_t;

endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
    import cfg_resp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    output logic        accept,
    output logic        exec,
    output logic        ack,
    output xfer_state_t state
);

    xfer_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        exec     = 1'b0;
        ack      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    state_nx = ST_EXEC;
                end
            end
            ST_EXEC: begin
                exec     = 1'b1;
                state_nx = ST_DONE;
            end
            ST_DONE: begin
                ack = 1'b1;
                if (req) begin
                    accept   = 1'b1;
                    state_nx = ST_EXEC;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/cfg_image.sv
module cfg_image
    import cfg_resp_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IO_WINDOW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [HDR_DW_W-1:0]           dw,
    input  logic [3:0]                    be,
    input  logic                          aligned,
    input  logic [31:0]                   wdata,
    output logic [MAX_BARS-1:0][31:0]     bars,
    output logic [7:0]                    int_line
);

    localparam logic [31:0] SIZE_MASK = ~(32'(IO_WINDOW) - 32'd1);

    logic full_dw;
    assign full_dw = wr && (be == 4'hF) && aligned;

    for (genvar i = 0; i < MAX_BARS; i++) begin : g_bar
        if (i < NUM_PORTS) begin : g_live
            logic [31:0] q;
            logic        hit;
            assign hit = full_dw && (dw == DW_BAR0 + HDR_DW_W'(i));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= BAR_IO_RST;
                end else if (hit) begin
                    if (wdata == 32'hFFFF_FFFF)
                        q <= {SIZE_MASK[31:2], q[1:0]};
                    else
                        q <= {wdata[31:2], q[1:0]};
                end
            end
            assign bars[i] = q;
        end else begin : g_tied
            assign bars[i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            int_line <= 8'h00;
        else if (wr && dw == DW_INTR && be[0])
            int_line <= wdata[7:0];
    end

endmodule

// File: rtl/cfg_readmux.sv
module cfg_readmux
    import cfg_resp_pkg::*;
(
    input  logic [HDR_DW_W-1:0]       dw,
    input  logic                      in_hdr,
    input  logic [3:0]                be,
    input  logic [MAX_BARS-1:0][31:0] bars,
    input  logic [7:0]                int_line,
    output logic [31:0]               word
);

    logic [31:0] raw;

    always_comb begin
        raw = 32'h0;
        if (in_hdr) begin
            case (dw)
                DW_CMD:               raw = CMD_STAT_VAL;
                DW_CLASS:             raw = CLASS_VAL;
                DW_BAR0:              raw = bars[0];
                DW_BAR0 + 6'd1:       raw = bars[1];
                DW_INTR:              raw = {16'h0000, INT_PIN_VAL, int_line};
                default:              raw = 32'h0;
            endcase
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign word[8*k +: 8] = be[k] ? raw[8*k +: 8] : 8'h00;
    end

endmodule

// File: rtl/pci_cfg_responder.sv
module pci_cfg_responder
    import cfg_resp_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PORTS = 2,
    parameter int IO_WINDOW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic              ack,
    output logic [31:0]       rdata
);

    localparam int HDR_ADDR_W = $clog2(HDR_BYTES);

    xfer_state_t             state;
    logic                    accept;
    logic                    exec;
    cfg_req_t                req_q;
    logic                    in_hdr_d;
    logic [MAX_BARS-1:0][31:0] bars;
    logic [7:0]              int_line;
    logic [31:0]             rd_word;
    logic [31:0]             rdata_q;

    if (ADDR_W > HDR_ADDR_W) begin : g_range
        assign in_hdr_d = ~|addr[ADDR_W-1:HDR_ADDR_W];
    end else begin : g_full
        assign in_hdr_d = 1'b1;
    end

    cfg_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .accept (accept),
        .exec   (exec),
        .ack    (ack),
        .state  (state)
    );

    // capture the request on the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.we      <= we;
            req_q.be      <= be;
            req_q.dw      <= addr[HDR_ADDR_W-1:2];
            req_q.in_hdr  <= in_hdr_d;
            req_q.aligned <= (addr[1:0] == 2'b00);
            req_q.wdata   <= wdata;
        end
    end

    cfg_image #(
        .NUM_PORTS (NUM_PORTS),
        .IO_WINDOW (IO_WINDOW)
    ) u_image (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (exec && req_q.we && req_q.in_hdr),
        .dw       (req_q.dw),
        .be       (req_q.be),
        .aligned  (req_q.aligned),
        .wdata    (req_q.wdata),
        .bars     (bars),
        .int_line (int_line)
    );

    cfg_readmux u_rmux (
        .dw       (req_q.dw),
        .in_hdr   (req_q.in_hdr),
        .be       (req_q.be),
        .bars     (bars),
        .int_line (int_line),
        .word     (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= 32'h0;
        else if (exec)
            rdata_q <= req_q.we ? 32'h0 : rd_word;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pci_cfg_responder_chk.sv
module pci_cfg_responder_chk
    import cfg_resp_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                accept,
    input logic                ack,
    input logic [31:0]         rdata,
    input logic                cap_we,
    input logic [3:0]          cap_be,
    input logic [HDR_DW_W-1:0] cap_dw,
    input logic                cap_in_hdr
);

    logic rd_done;
    assign rd_done = ack && !cap_we;

    // R2
    ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ack ##1 ack);

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R2
    wr_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && cap_we) |-> (rdata == 32'h0));

    // R4
    beyond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !cap_in_hdr) |-> (rdata == 32'h0));

    // R6
    bar_io_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && cap_in_hdr && cap_dw == DW_BAR0 && cap_be[0]) |-> (rdata[1:0] == 2'b01));

    // R9
    cmd_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && cap_in_hdr && cap_dw == DW_CMD && cap_be == 4'hF) |-> (rdata == CMD_STAT_VAL));

    // R10
    int_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && cap_in_hdr && cap_dw == DW_INTR && cap_be[1]) |-> (rdata[15:8] == INT_PIN_VAL));

    if (NUM_PORTS < 2) begin : g_single
        // R7
        bar1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_done && cap_in_hdr && cap_dw == DW_BAR0 + 6'd1) |-> (rdata == 32'h0));
    end

endmodule

bind pci_cfg_responder pci_cfg_responder_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .ack        (ack),
    .rdata      (rdata),
    .cap_we     (req_q.we),
    .cap_be     (req_q.be),
    .cap_dw     (req_q.dw),
    .cap_in_hdr (req_q.in_hdr)
);

// File: tb/pci_cfg_responder_tb.sv
module pci_cfg_responder_tb;

    localparam int ADDR_W = 12;
    localparam int NV     = 39;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0]        be = 4'h0;
    logic [31:0]       wdata = 32'h0;
    logic              ack, ack1;
    logic [31:0]       rdata, rdata1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pci_cfg_responder #(.ADDR_W(ADDR_W), .NUM_PORTS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .be(be), .wdata(wdata), .ack(ack), .rdata(rdata)
    );

    pci_cfg_responder #(.ADDR_W(ADDR_W), .NUM_PORTS(1)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .be(be), .wdata(wdata), .ack(ack1), .rdata(rdata1)
    );

    // {tag, we, be, addr, wdata, expected rdata}
    localparam logic [84:0] VEC [NV] = '{
        {4'd1,  1'b0, 4'hF, 12'h004, 32'h0,         32'h0200_0001}, // R1
        {4'd1,  1'b0, 4'hF, 12'h008, 32'h0,         32'h0700_0210}, // R1
        {4'd1,  1'b0, 4'hF, 12'h010, 32'h0,         32'h0000_0001}, // R1
        {4'd7,  1'b0, 4'hF, 12'h014, 32'h0,         32'h0000_0001}, // R7
        {4'd1,  1'b0, 4'hF, 12'h03C, 32'h0,         32'h0000_0100}, // R1
        {4'd1,  1'b0, 4'hF, 12'h034, 32'h0,         32'h0}, // R1
        {4'd3,  1'b0, 4'h2, 12'h00A, 32'h0,         32'h0000_0200}, // R3
        {4'd3,  1'b0, 4'hC, 12'h006, 32'h0,         32'h0200_0000}, // R3
        {4'd3,  1'b0, 4'h0, 12'h008, 32'h0,         32'h0}, // R3
        {4'd5,  1'b1, 4'hF, 12'h010, 32'hFFFF_FFFF, 32'h0}, // R5
        {4'd5,  1'b0, 4'hF, 12'h010, 32'h0,         32'hFFFF_FFF9}, // R5
        {4'd6,  1'b1, 4'hF, 12'h010, 32'h0000_C0F2, 32'h0}, // R6
        {4'd6,  1'b0, 4'hF, 12'h010, 32'h0,         32'h0000_C0F1}, // R6
        {4'd11, 1'b1, 4'h3, 12'h010, 32'h1234_5678, 32'h0}, // R11
        {4'd11, 1'b0, 4'hF, 12'h010, 32'h0,         32'h0000_C0F1}, // R11
        {4'd11, 1'b1, 4'hF, 12'h012, 32'hFFFF_FFFF, 32'h0}, // R11
        {4'd11, 1'b0, 4'hF, 12'h010, 32'h0,         32'h0000_C0F1}, // R11
        {4'd7,  1'b1, 4'hF, 12'h014, 32'hFFFF_FFFF, 32'h0}, // R7
        {4'd7,  1'b0, 4'hF, 12'h014, 32'h0,         32'hFFFF_FFF9}, // R7
        {4'd8,  1'b1, 4'hF, 12'h018, 32'hFFFF_FFFF, 32'h0}, // R8
        {4'd8,  1'b0, 4'hF, 12'h018, 32'h0,         32'h0}, // R8
        {4'd8,  1'b1, 4'hF, 12'h020, 32'hABCD_0001, 32'h0}, // R8
        {4'd8,  1'b0, 4'hF, 12'h020, 32'h0,         32'h0}, // R8
        {4'd9,  1'b1, 4'hF, 12'h004, 32'h0,         32'h0}, // R9
        {4'd9,  1'b0, 4'hF, 12'h004, 32'h0,         32'h0200_0001}, // R9
        {4'd9,  1'b1, 4'hF, 12'h008, 32'hFFFF_FFFF, 32'h0}, // R9
        {4'd9,  1'b0, 4'hF, 12'h008, 32'h0,         32'h0700_0210}, // R9
        {4'd9,  1'b1, 4'hF, 12'h040, 32'hDEAD_BEEF, 32'h0}, // R9
        {4'd9,  1'b0, 4'hF, 12'h040, 32'h0,         32'h0}, // R9
        {4'd10, 1'b1, 4'hF, 12'h03C, 32'h0000_FF5A, 32'h0}, // R10
        {4'd10, 1'b0, 4'hF, 12'h03C, 32'h0,         32'h0000_015A}, // R10
        {4'd10, 1'b1, 4'h2, 12'h03C, 32'h0000_0700, 32'h0}, // R10
        {4'd10, 1'b0, 4'hF, 12'h03C, 32'h0,         32'h0000_015A}, // R10
        {4'd10, 1'b1, 4'h1, 12'h03C, 32'h0000_00A5, 32'h0}, // R10
        {4'd10, 1'b0, 4'hF, 12'h03C, 32'h0,         32'h0000_01A5}, // R10
        {4'd4,  1'b0, 4'hF, 12'h100, 32'h0,         32'h0}, // R4
        {4'd4,  1'b1, 4'hF, 12'h110, 32'hFFFF_FFFF, 32'h0}, // R4
        {4'd4,  1'b0, 4'hF, 12'h010, 32'h0,         32'h0000_C0F1}, // R4
        {4'd4,  1'b0, 4'hF, 12'h810, 32'h0,         32'h0}  // R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // starts and ends just after a falling edge with the controller idle
    task automatic xfer(input logic w, input logic [3:0] b, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, output logic ack_mid, output logic ack_end,
                        output logic [31:0] rd, output logic [31:0] rd1);
        req = 1'b1; we = w; be = b; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        ack_mid = ack;
        @(negedge clk);
        ack_end = ack;
        rd  = rdata;
        rd1 = rdata1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic am, ae;
        logic [31:0] rd, rd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state seen at the ports before any access
        check("R1 ack idle", {31'h0, ack}, 32'h0);
        check("R1 rdata idle", rdata, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][80], VEC[i][79:76], VEC[i][75:64], VEC[i][63:32], am, ae, rd, rd1);
            check($sformatf("R%0d vec %0d", VEC[i][84:81], i), rd, VEC[i][31:0]);
            check($sformatf("R2 ack vec %0d", i), {30'h0, am, ae}, 32'h1);
        end

        // R7 single-port BAR1 stays zero after the table's all-ones write
        xfer(1'b0, 4'hF, 12'h014, 32'h0, am, ae, rd, rd1);
        check("R7 two-port bar1", rd, 32'hFFFF_FFF9);
        check("R7 single-port bar1", rd1, 32'h0);
        xfer(1'b1, 4'hF, 12'h014, 32'h0000_5000, am, ae, rd, rd1);
        xfer(1'b0, 4'hF, 12'h014, 32'h0, am, ae, rd, rd1);
        check("R7 two-port bar1 addr", rd, 32'h0000_5001);
        check("R7 single-port bar1 addr", rd1, 32'h0);

        // R2 request held into the execute cycle is dropped
        req = 1'b1; we = 1'b0; be = 4'hF; addr = 12'h03C; wdata = 32'h0;
        @(negedge clk);
        we = 1'b1; wdata = 32'h0000_0077;   // still requesting during execute
        @(negedge clk);
        req = 1'b0;
        check("R2 ack after held req", {31'h0, ack}, 32'h1);
        check("R2 read during held req", rdata, 32'h0000_01A5);
        @(negedge clk);
        check("R2 ack drops", {31'h0, ack}, 32'h0);
        xfer(1'b0, 4'hF, 12'h03C, 32'h0, am, ae, rd, rd1);
        check("R2 dropped write no effect", rd, 32'h0000_01A5);

        // R12 read accepted in the write's ack cycle
        req = 1'b1; we = 1'b1; be = 4'hF; addr = 12'h010; wdata = 32'h0000_E000;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check("R12 write ack", {31'h0, ack}, 32'h1);
        req = 1'b1; we = 1'b0; wdata = 32'h0;
        @(negedge clk);
        req = 1'b0;
        check("R12 gap cycle", {31'h0, ack}, 32'h0);
        @(negedge clk);
        check("R12 read ack", {31'h0, ack}, 32'h1);
        check("R12 read data", rdata, 32'h0000_E001);
        @(negedge clk);

        // R1 reset in mid-run restores the image
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        xfer(1'b0, 4'hF, 12'h010, 32'h0, am, ae, rd, rd1);
        check("R1 bar0 after reset", rd, 32'h0000_0001);
        xfer(1'b0, 4'hF, 12'h014, 32'h0, am, ae, rd, rd1);
        check("R1 bar1 after reset", rd, 32'h0000_0001);
        check("R7 single-port bar1 after reset", rd1, 32'h0);
        xfer(1'b0, 4'hF, 12'h03C, 32'h0, am, ae, rd, rd1);
        check("R1 intr dword after reset", rd, 32'h0000_0100);

        finish_run();
    end

endmodule